// File: doc/BRIEF.md
# Bit-Command General-Purpose I/O Port

This block is a small bidirectional I/O port that a processor drives through two 16-bit registers on a simple synchronous register bus. The first register is the port register. Its upper byte sets the direction of each pin, and its lower byte reads back the level of each pin. The second register is the action register. It holds a per-pin selector byte and a per-pin operand byte. Together these two bits tell each output pin to go low, go high, keep its level or invert.

Software can change any subset of pins with a single write. It does not need a read-modify-write, because pins whose action is "keep" are left alone. Each pin's output latch is kept while the pin is an input. A pin that is switched back to an output therefore drives its earlier level again. The port width is a parameter; the default is 8 pins and 4 is the reduced build. Pad electrical behaviour, pull-ups and alternate functions lie outside the block.

Top module: `gpio_port`

## Requirements
- R1: After reset every pin is an input (pad_oe_o all zero), every output latch (pad_o) is zero, and the action register reads back as zero.
- R2: A write to address 0 loads the direction bits from wdata_i[8+W-1:8], where 1 means output and 0 means input. pad_oe_o shows the new directions in the cycle after the write.
- R3: wdata_i[7:0] of a write to address 0 has no effect on any output latch.
- R4: A write to address 1 takes the selector from wdata_i[8+W-1:8] and the operand from wdata_i[W-1:0]. In the next cycle each output pin's latch follows its code (selector, operand): 00 drives low, 01 drives high, 10 keeps the level, 11 inverts.
- R5: An action write leaves the latch of every input pin unchanged. A pin returned to output mode drives the level it held before.
- R6: A read of address 0 returns the directions in bits [8+W-1:8] and the pin levels in bits [W-1:0]. Output pins return their latch. Input pins return the pad level through a two-flop synchroniser, so a pad change shows after two rising edges.
- R7: A read of address 1 returns the selector and operand exactly as last written.
- R8: rdata_o is valid in the same cycle as re_i and is zero when re_i is low. Bits above W in each byte read as zero.
- R9: When no write takes place, pad_o and pad_oe_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 1 | 0 selects the port register, 1 selects the action register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational while re_i is high |
| pad_i | input | W | Pad input levels (asynchronous) |
| pad_o | output | W | Output latch per pin |
| pad_oe_o | output | W | Output enable per pin |

## Verification
A wrong direction bit shows on pad_oe_o in the cycle after the write that set it. A wrong action decode shows on pad_o in the cycle after the action write. A latch that is disturbed while its pin is an input stays hidden until the pin is made an output again. It then shows on pad_o at once, so the bench runs direction round trips to expose it. A synchroniser with the wrong depth shows only as a read taken one edge too early or too late after a pad change. The bench therefore reads the port register exactly one and two edges after a change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned REG_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    SEL_PORT = 1'b0,
    SEL_ACT  = 1'b1
  } reg_sel_e;

  typedef enum logic [1:0] {
    ACT_LOW  = 2'b00,
    ACT_HIGH = 2'b01,
    ACT_KEEP = 2'b10,
    ACT_INV  = 2'b11
  } pin_act_e;

  function automatic logic apply_act(pin_act_e act, logic cur);
    logic nxt;
    unique case (act)
      ACT_LOW:  nxt = 1'b0;
      ACT_HIGH: nxt = 1'b1;
      ACT_KEEP: nxt = cur;
      default:  nxt = ~cur;
    endcase
    return nxt;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         act_stb_i,
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] opd_i,
  input  logic [W-1:0] dir_i,
  output logic [W-1:0] lat_o
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    logic     lat_q;
    pin_act_e act;
    assign act = pin_act_e'({sel_i[p], opd_i[p]});

    // input pins keep their latch so a later return to output restores it
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lat_q <= 1'b0;
      else if (act_stb_i && dir_i[p]) lat_q <= apply_act(act, lat_q);
    end

    assign lat_o[p] = lat_q;
  end
endmodule

// File: rtl/gpio_bus_regs.sv
module gpio_bus_regs
  import gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [W-1:0]     level_i,
  output logic [REG_W-1:0] rdata_o,
  output logic [W-1:0]     dir_o,
  output logic [W-1:0]     sel_o,
  output logic [W-1:0]     opd_o,
  output logic             act_stb_o
);
  localparam int unsigned HI = BYTE_W;

  reg_sel_e     sel_reg;
  logic [W-1:0] dir_q, sel_q, opd_q;
  logic         wr_port, wr_act;

  assign sel_reg = reg_sel_e'(addr_i);
  assign wr_port = we_i && (sel_reg == SEL_PORT);
  assign wr_act  = we_i && (sel_reg == SEL_ACT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= '0;
    else if (wr_port) dir_q <= wdata_i[HI +: W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      opd_q <= '0;
    end else if (wr_act) begin
      sel_q <= wdata_i[HI +: W];
      opd_q <= wdata_i[0 +: W];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (re_i) begin
      if (sel_reg == SEL_PORT) begin
        rdata_o[HI +: W] = dir_q;
        rdata_o[0 +: W]  = level_i;
      end else begin
        rdata_o[HI +: W] = sel_q;
        rdata_o[0 +: W]  = opd_q;
      end
    end
  end

  // action decoded from the bus word itself, applied on this edge
  assign dir_o     = dir_q;
  assign sel_o     = wdata_i[HI +: W];
  assign opd_o     = wdata_i[0 +: W];
  assign act_stb_o = wr_act;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned W          = 8,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic         re_i,
  input  logic         addr_i,
  input  logic [15:0]  wdata_i,
  output logic [15:0]  rdata_o,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe_o
);
  logic [W-1:0] dir, sel, opd, lat, pad_sync, level;
  logic         act_stb;

  gpio_in_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pad_i),
    .sync_o  (pad_sync)
  );

  gpio_bus_regs #(.W(W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .re_i      (re_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .level_i   (level),
    .rdata_o   (rdata_o),
    .dir_o     (dir),
    .sel_o     (sel),
    .opd_o     (opd),
    .act_stb_o (act_stb)
  );

  gpio_out_latch #(.W(W)) u_lat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_stb_i (act_stb),
    .sel_i     (sel),
    .opd_i     (opd),
    .dir_i     (dir),
    .lat_o     (lat)
  );

  assign level    = (dir & lat) | (~dir & pad_sync);
  assign pad_o    = lat;
  assign pad_oe_o = dir;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         we_i,
  input logic         re_i,
  input logic         addr_i,
  input logic [15:0]  wdata_i,
  input logic [15:0]  rdata_o,
  input logic [W-1:0] pad_o,
  input logic [W-1:0] pad_oe_o
);
  logic [W-1:0] w_sel, w_opd, want;
  assign w_sel = wdata_i[8 +: W];
  assign w_opd = wdata_i[0 +: W];
  // expected latch value per pin when the pin is an output
  assign want  = (~w_sel & w_opd) | (w_sel & ~w_opd & pad_o) | (w_sel & w_opd & ~pad_o);

  p_dir_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i) |=> pad_oe_o == $past(w_sel));

  p_port_low_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i) |=> $stable(pad_o));

  p_act_apply_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i) |=> ((pad_o ^ $past(want)) & $past(pad_oe_o)) == '0);

  p_input_latch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i) |=> ((pad_o ^ $past(pad_o)) & ~$past(pad_oe_o)) == '0);

  p_idle_read_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |-> rdata_o == '0);

  p_no_write_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(pad_o) && $stable(pad_oe_o)));
endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .re_i     (re_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .pad_o    (pad_o),
  .pad_oe_o (pad_oe_o)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
  localparam int W = 8;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         we = 0, re = 0, addr = 0;
  logic [15:0]  wdata = '0;
  logic [15:0]  rdata;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, pad_oe;

  int checks = 0, fails = 0;
  logic [W-1:0] m_dir = '0, m_lat = '0, m_sel = '0, m_opd = '0;

  always #10 clk = ~clk;

  gpio_port #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out), .pad_oe_o(pad_oe)
  );

  function automatic logic [W-1:0] f_act(logic [W-1:0] s, logic [W-1:0] d,
                                         logic [W-1:0] cur, logic [W-1:0] dir);
    logic [W-1:0] r = cur;
    for (int i = 0; i < W; i++)
      if (dir[i])
        case ({s[i], d[i]})
          2'b00: r[i] = 1'b0;
          2'b01: r[i] = 1'b1;
          2'b10: r[i] = cur[i];
          default: r[i] = ~cur[i];
        endcase
    return r;
  endfunction

  function automatic logic [15:0] f_port(logic [W-1:0] dir, logic [W-1:0] lat, logic [W-1:0] pad);
    logic [15:0] r = '0;
    r[8 +: W] = dir;
    r[0 +: W] = (dir & lat) | (~dir & pad);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    if (a) begin
      m_lat = f_act(d[8 +: W], d[0 +: W], m_lat, m_dir);
      m_sel = d[8 +: W]; m_opd = d[0 +: W];
    end else m_dir = d[8 +: W];
    @(negedge clk);
    we = 0;
  endtask

  task automatic outs(input string req);
    chk(pad_oe === m_dir, req, 16'(pad_oe), 16'(m_dir));
    chk(pad_out === m_lat, req, 16'(pad_out), 16'(m_lat));
  endtask

  task automatic rd(input logic a, input logic [15:0] exp, input string req);
    @(negedge clk);
    re = 1; addr = a;
    #1 chk(rdata === exp, req, rdata, exp);
    re = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    outs("R1");
    rd(1, 16'h0000, "R1");
    // R8 idle read is zero
    #1 chk(rdata === 16'h0, "R8", rdata, 16'h0);

    // R2 directions, R4 each code
    wr(0, 16'hFF00);
    outs("R2");
    wr(1, 16'h00FF); outs("R4 high");
    wr(1, 16'h0000); outs("R4 low");
    wr(1, 16'hFF0F); outs("R4 keep/inv");
    wr(1, 16'hF0AA); outs("R4 mixed");
    rd(1, 16'hF0AA, "R7");

    // R3 low byte of port write ignored
    wr(0, 16'hFF55); outs("R3");
    wr(0, 16'hFFAA); outs("R3");

    // R5 round trip through input mode
    wr(1, 16'h00F0);
    wr(0, 16'h0F00);
    wr(1, 16'h00FF); outs("R5 input untouched");
    wr(0, 16'hFF00); outs("R5 restored");

    // R6 sync latency on input pins
    wr(0, 16'h0000);
    pad_in = 8'hC3;
    repeat (3) @(negedge clk);
    rd(0, f_port(m_dir, m_lat, 8'hC3), "R6 settled");
    @(negedge clk); pad_in = 8'h3C;
    @(negedge clk); re = 1; addr = 0;
    #1 chk(rdata === f_port(m_dir, m_lat, 8'hC3), "R6 one edge", rdata, f_port(m_dir, m_lat, 8'hC3));
    @(negedge clk);
    #1 chk(rdata === f_port(m_dir, m_lat, 8'h3C), "R6 two edges", rdata, f_port(m_dir, m_lat, 8'h3C));
    re = 0;

    // R9 idle hold
    repeat (4) @(negedge clk);
    outs("R9");

    // constrained random
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 5);
      case (op)
        0: begin wr(0, 16'($urandom)); outs("R2/R3 rand"); end
        1, 2: begin wr(1, 16'($urandom)); outs("R4/R5 rand"); end
        3: rd(0, f_port(m_dir, m_lat, pad_in), "R6 rand");
        4: rd(1, {m_sel, m_opd}, "R7 rand");
        default: begin
          pad_in = W'($urandom);
          repeat (3) @(negedge clk);
          outs("R9 rand");
        end
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule